// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block picks the handshake that a USB device controller sends back for each token that arrives on its control endpoint. It keeps a small amount of state for each transfer direction: whether a stage is primed, whether software has stalled the direction, and whether a prime request is still being worked on. Software asks for a direction to be primed, and the block settles that request into a completed or a failed result a fixed number of cycles later. A failed result occurs when a SETUP arrives while the request is still pending.

A SETUP token is always accepted. It cancels any stage that is primed or still being primed, releases a stall, and raises a sticky setup-received flag. Software reads that flag after priming to detect a newer request. A status stage is primed as a zero-byte transfer and goes through the same token handling as a data stage. Packet serialisation, CRC, descriptor fetch and the data buffer sit outside this block.

Direction index 0 is the OUT (host-to-device) side and index 1 is the IN (device-to-host) side, in every two-bit vector. Token type encoding: 0 = SETUP, 1 = IN, 2 = OUT, 3 = reserved. A reserved token gives no response. Response encoding: 0 = none, 1 = ACK, 2 = NAK, 3 = STALL, 4 = NYET, 5 = transmit data. The response and the error pulse are registered and appear one clock after the token is sampled.

Top module: `ctl_ep_responder`

## Requirements
- R1: A SETUP token (type 0) is answered with ACK (code 1) whatever the state of either direction is.
- R2: An IN token (type 1) gets NAK (2) when the IN direction is not ready. It gets transmit data (5) when the direction is ready, and STALL (3) when the direction is stalled.
- R3: An OUT token (type 2) gets NAK when not ready and STALL when stalled. On a ready direction it gets ACK and the OUT ready bit clears when `lastDesc` is 1. It gets NYET (4) and the ready bit stays set when `lastDesc` is 0.
- R4: A prime request raises the pending bit of that direction for exactly PRIME_LAT cycles. When the pending bit drops, the ready bit reads 1.
- R5: If a SETUP arrives while a prime is pending, or in the same cycle as the request, the pending bit still drops on time but the ready bit stays 0.
- R6: A SETUP clears the ready bit of both directions in the cycle after it is sampled.
- R7: `setupStat` is set by every SETUP and cleared only by `setupClr`. A SETUP in the same cycle as the clear leaves it set.
- R8: A stall takes priority over the ready state for IN and OUT tokens. The next SETUP removes the stall.
- R9: An IN underflow or OUT overflow (`xferErr` on a ready, unstalled direction) yields response code 0 with `respValid` high. `errPulse` is high for exactly one cycle and the ready bit is unchanged.
- R10: An IN token that sends data with `lastDesc` 1 clears the IN ready bit. With `lastDesc` 0 the IN ready bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | A decoded token is present this cycle |
| tokType | input | 2 | Token type: 0 SETUP, 1 IN, 2 OUT |
| lastDesc | input | 1 | The current transaction fills the last primed descriptor |
| xferErr | input | 1 | Underflow (IN) or overflow (OUT) on this transaction |
| primeReq | input | 2 | Prime request pulse per direction (bit0 OUT, bit1 IN) |
| stallSet | input | 2 | Stall request pulse per direction |
| setupClr | input | 1 | Write-one-to-clear for the setup-received flag |
| respValid | output | 1 | A response is issued this cycle |
| resp | output | 3 | Response code |
| errPulse | output | 1 | One-cycle transaction error flag |
| primePend | output | 2 | Prime pending per direction |
| epReady | output | 2 | Direction primed and ready per direction |
| epStall | output | 2 | Direction stalled |
| setupStat | output | 1 | Setup-received flag |

## Verification
The bench targets the SETUP that lands mid-prime. A design that ignores it would report a completed prime and let stale data answer the new request. It also checks the same-cycle race between a SETUP and the flag clear, where a wrong priority would lose the setup notice. It separates ACK from NYET on OUT: a design that mixes them up either ends the transfer early or never frees the descriptor. It then checks that a stall beats a ready direction, and that an error transaction issues no handshake while keeping the ready bit.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_OUT = 0;
  localparam int DIR_IN  = 1;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_NYET  = 3'd4,
    RSP_DATA  = 3'd5
  } resp_e;

  // strobes from the decision logic to the state keeper
  typedef struct packed {
    logic               setup;
    logic [NUM_DIR-1:0] consume;
  } ep_strobe_t;
endpackage

// File: rtl/ctl_ep_state.sv
module ctl_ep_state
  import ctl_ep_pkg::*;
#(
  parameter int PRIME_LAT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ep_strobe_t         strobe,
  input  logic [NUM_DIR-1:0] primeReq,
  input  logic [NUM_DIR-1:0] stallSet,
  input  logic               setupClr,
  output logic [NUM_DIR-1:0] pend,
  output logic [NUM_DIR-1:0] ready,
  output logic [NUM_DIR-1:0] stall,
  output logic               setupStat
);
  localparam int CNT_W = $clog2(PRIME_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PRIME_LAT - 1);

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [CNT_W-1:0] cnt;
    logic             failed;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[d]  <= 1'b0;
        ready[d] <= 1'b0;
        cnt      <= '0;
        failed   <= 1'b0;
      end else if (pend[d]) begin
        if (strobe.setup) failed <= 1'b1;
        if (cnt == '0) begin
          pend[d]  <= 1'b0;
          ready[d] <= !(failed || strobe.setup);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (primeReq[d]) begin
        pend[d]  <= 1'b1;
        cnt      <= CNT_LOAD;
        failed   <= strobe.setup;
        ready[d] <= 1'b0;
      end else if (strobe.setup || strobe.consume[d]) begin
        ready[d] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) stall[d] <= 1'b0;
      else       stall[d] <= stallSet[d] || (stall[d] && !strobe.setup);
    end

    assert_setup_drops_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setup |=> !ready[d]);
    assert_setup_unstalls_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.setup && !stallSet[d]) |=> !stall[d]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) setupStat <= 1'b0;
    else       setupStat <= strobe.setup || (setupStat && !setupClr);
  end

  assert_setup_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setup |=> setupStat);
endmodule

// File: rtl/ctl_ep_decide.sv
module ctl_ep_decide
  import ctl_ep_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tokValid,
  input  tok_e               tokType,
  input  logic               lastDesc,
  input  logic               xferErr,
  input  logic [NUM_DIR-1:0] ready,
  input  logic [NUM_DIR-1:0] stall,
  output ep_strobe_t         strobe,
  output logic               respValid,
  output resp_e              resp,
  output logic               errPulse
);
  resp_e nextResp;
  logic  nextValid;
  logic  nextErr;

  always_comb begin
    strobe    = '0;
    nextResp  = RSP_NONE;
    nextValid = 1'b0;
    nextErr   = 1'b0;
    if (tokValid) begin
      unique case (tokType)
        TOK_SETUP: begin
          nextValid    = 1'b1;
          nextResp     = RSP_ACK;
          strobe.setup = 1'b1;
        end
        TOK_IN: begin
          nextValid = 1'b1;
          if (stall[DIR_IN])       nextResp = RSP_STALL;
          else if (!ready[DIR_IN]) nextResp = RSP_NAK;
          else if (xferErr)        nextErr  = 1'b1;
          else begin
            nextResp               = RSP_DATA;
            strobe.consume[DIR_IN] = lastDesc;
          end
        end
        TOK_OUT: begin
          nextValid = 1'b1;
          if (stall[DIR_OUT])       nextResp = RSP_STALL;
          else if (!ready[DIR_OUT]) nextResp = RSP_NAK;
          else if (xferErr)         nextErr  = 1'b1;
          else if (lastDesc) begin
            nextResp                = RSP_ACK;
            strobe.consume[DIR_OUT] = 1'b1;
          end else                  nextResp = RSP_NYET;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      resp      <= RSP_NONE;
      errPulse  <= 1'b0;
    end else begin
      respValid <= nextValid;
      resp      <= nextResp;
      errPulse  <= nextErr;
    end
  end

  assert_setup_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType == TOK_SETUP) |=> (respValid && resp == RSP_ACK));
  assert_in_stall_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType == TOK_IN && stall[DIR_IN]) |=> (resp == RSP_STALL));
  assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (respValid && resp == RSP_NONE));
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !tokValid) |=> !errPulse);
endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
  import ctl_ep_pkg::*;
#(
  parameter int PRIME_LAT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokValid,
  input  logic [1:0] tokType,
  input  logic       lastDesc,
  input  logic       xferErr,
  input  logic [1:0] primeReq,
  input  logic [1:0] stallSet,
  input  logic       setupClr,
  output logic       respValid,
  output logic [2:0] resp,
  output logic       errPulse,
  output logic [1:0] primePend,
  output logic [1:0] epReady,
  output logic [1:0] epStall,
  output logic       setupStat
);
  ep_strobe_t strobe;
  resp_e      respE;

  ctl_ep_decide u_decide (
    .clk      (clk),
    .rstN     (rstN),
    .tokValid (tokValid),
    .tokType  (tok_e'(tokType)),
    .lastDesc (lastDesc),
    .xferErr  (xferErr),
    .ready    (epReady),
    .stall    (epStall),
    .strobe   (strobe),
    .respValid(respValid),
    .resp     (respE),
    .errPulse (errPulse)
  );

  ctl_ep_state #(.PRIME_LAT(PRIME_LAT)) u_state (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .primeReq (primeReq),
    .stallSet (stallSet),
    .setupClr (setupClr),
    .pend     (primePend),
    .ready    (epReady),
    .stall    (epStall),
    .setupStat(setupStat)
  );

  assign resp = respE;
endmodule

// File: tb/ctl_ep_responder_bench.sv
`timescale 1ns/1ps
module ctl_ep_responder_bench;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokValid = 1'b0, lastDesc = 1'b0, xferErr = 1'b0, setupClr = 1'b0;
  logic [1:0] tokType = 2'd0, primeReq = 2'd0, stallSet = 2'd0;
  logic respValid, errPulse, setupStat;
  logic [2:0] resp;
  logic [1:0] primePend, epReady, epStall;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_ep_responder #(.PRIME_LAT(LAT)) u_ctl_ep_responder (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokType(tokType),
    .lastDesc(lastDesc), .xferErr(xferErr), .primeReq(primeReq),
    .stallSet(stallSet), .setupClr(setupClr), .respValid(respValid),
    .resp(resp), .errPulse(errPulse), .primePend(primePend),
    .epReady(epReady), .epStall(epStall), .setupStat(setupStat));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a token at a negedge; response is checked at the next negedge
  task automatic sendTok(logic [1:0] t, logic last, logic err, logic clr);
    @(negedge clk);
    tokValid = 1'b1; tokType = t; lastDesc = last; xferErr = err; setupClr = clr;
    @(negedge clk);
    tokValid = 1'b0; lastDesc = 1'b0; xferErr = 1'b0; setupClr = 1'b0;
  endtask

  task automatic prime(int d, string tag);
    int cnt;
    @(negedge clk); primeReq[d] = 1'b1;
    @(negedge clk); primeReq = 2'd0;
    cnt = 0;
    while (primePend[d] && cnt < 50) begin cnt++; @(negedge clk); end
    check({tag, " pending length"}, cnt, LAT);
    check({tag, " ready after prime"}, int'(epReady[d]), 1);
  endtask

  task automatic tReset();
    check("R1 reset respValid", int'(respValid), 0);
    check("R4 reset pend", int'(primePend), 0);
    check("R4 reset ready", int'(epReady), 0);
    check("R7 reset setupStat", int'(setupStat), 0);
    check("R9 reset err", int'(errPulse), 0);
  endtask

  task automatic tUnprimed();
    sendTok(2'd1, 0, 0, 0);
    check("R2 IN unprimed NAK", int'(resp), 2);
    check("R2 respValid", int'(respValid), 1);
    sendTok(2'd2, 0, 0, 0);
    check("R3 OUT unprimed NAK", int'(resp), 2);
    sendTok(2'd3, 0, 0, 0);
    check("R2 reserved token silent", int'(respValid), 0);
  endtask

  task automatic tSetupFlag();
    sendTok(2'd0, 0, 0, 0);
    check("R1 SETUP ACK", int'(resp), 1);
    check("R7 setupStat set", int'(setupStat), 1);
    @(negedge clk); setupClr = 1'b1;
    @(negedge clk); setupClr = 1'b0;
    check("R7 W1C clears", int'(setupStat), 0);
    sendTok(2'd0, 0, 0, 1);
    check("R7 setup beats clear", int'(setupStat), 1);
  endtask

  task automatic tInData();
    prime(1, "R4 IN");
    sendTok(2'd1, 0, 0, 0);
    check("R2 IN primed DATA", int'(resp), 5);
    check("R10 not last keeps ready", int'(epReady[1]), 1);
    sendTok(2'd1, 1, 0, 0);
    check("R10 last DATA", int'(resp), 5);
    check("R10 last clears ready", int'(epReady[1]), 0);
  endtask

  task automatic tOutData();
    prime(0, "R4 OUT");
    sendTok(2'd2, 0, 0, 0);
    check("R3 OUT NYET", int'(resp), 4);
    check("R3 NYET keeps ready", int'(epReady[0]), 1);
    sendTok(2'd2, 1, 0, 0);
    check("R3 OUT last ACK", int'(resp), 1);
    check("R3 ACK clears ready", int'(epReady[0]), 0);
  endtask

  task automatic tErr();
    prime(1, "R4 IN again");
    sendTok(2'd1, 1, 1, 0);
    check("R9 underflow resp none", int'(resp), 0);
    check("R9 underflow respValid", int'(respValid), 1);
    check("R9 err pulse", int'(errPulse), 1);
    check("R9 ready kept", int'(epReady[1]), 1);
    @(negedge clk);
    check("R9 err one cycle", int'(errPulse), 0);
    prime(0, "R4 OUT again");
    sendTok(2'd2, 1, 1, 0);
    check("R9 overflow err", int'(errPulse), 1);
    check("R9 overflow ready kept", int'(epReady[0]), 1);
  endtask

  task automatic tCancel();
    sendTok(2'd0, 0, 0, 0);
    check("R6 SETUP clears both ready", int'(epReady), 0);
    check("R1 ACK while primed", int'(resp), 1);
  endtask

  task automatic tFail();
    int cnt;
    @(negedge clk); primeReq = 2'b01;
    @(negedge clk); primeReq = 2'd0;
    tokValid = 1'b1; tokType = 2'd0;
    @(negedge clk); tokValid = 1'b0;
    check("R1 ACK during prime", int'(resp), 1);
    cnt = 0;
    while (primePend[0] && cnt < 50) begin cnt++; @(negedge clk); end
    check("R5 pend still clears", int'(primePend[0]), 0);
    check("R5 failed prime not ready", int'(epReady[0]), 0);
  endtask

  task automatic tStall();
    prime(1, "R4 IN stall");
    @(negedge clk); stallSet = 2'b11;
    @(negedge clk); stallSet = 2'd0;
    sendTok(2'd1, 1, 0, 0);
    check("R8 stall beats ready IN", int'(resp), 3);
    check("R8 ready untouched", int'(epReady[1]), 1);
    sendTok(2'd2, 1, 0, 0);
    check("R8 OUT stalled", int'(resp), 3);
    sendTok(2'd0, 0, 0, 0);
    check("R8 SETUP ACK when stalled", int'(resp), 1);
    check("R8 SETUP clears stall", int'(epStall), 0);
    sendTok(2'd1, 0, 0, 0);
    check("R8 IN after SETUP NAK", int'(resp), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUnprimed();
    tSetupFlag();
    tInData();
    tOutData();
    tErr();
    tCancel();
    tFail();
    tStall();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule